// File: doc/BRIEF.md
# Reset Supervisor with Pushbutton Debounce

This block turns two raw inputs into a clean processor reset. The first is a supply-fail flag, taken from an analog comparator outside the block, that reads high while the supply is out of tolerance. The second is an active-low pushbutton. The block drives two reset outputs, one active high and one active low, and the two are always complementary.

Both inputs first pass through synchronizer flops. A short pulse on the supply-fail flag is removed by a glitch filter. The button passes through a symmetric debouncer. A single hold state machine drives both outputs. Reset rises as soon as a filtered cause is present. It stays up while any cause remains. Once every cause has cleared, it stays up for a further hold period. For the button, the hold period is therefore measured from release. A cause that comes back during the hold period reasserts reset and restarts the hold period from zero.

All time constants are parameters counted in clock cycles: `SYNC_STAGES`, `GLITCH_CYC`, `DEBOUNCE_CYC` and `HOLD_CYC`. Below, S, G, D and H stand for these four parameters. An input change is counted from the first rising clock edge after the change.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, `rst_hi_o` is 1 and `rst_lo_o` is 0.
- R2: If `supply_fail_i` stays at 1 for at least G cycles, `rst_hi_o` rises on edge S+G+1 after the input rose.
- R3: A `supply_fail_i` pulse shorter than G cycles leaves both outputs unchanged.
- R4: If `button_n_i` stays at 0 (pressed) for at least D cycles, `rst_hi_o` rises on edge S+D+1 after the press.
- R5: A level change on `button_n_i` that lasts fewer than D cycles is ignored. This applies both to a short press from idle and to a short release bounce during a long press, which must not start the hold period.
- R6: When the supply-fail flag is the last cause to clear, `rst_hi_o` falls on edge S+2+H after `supply_fail_i` falls.
- R7: When the button is the last cause to clear, `rst_hi_o` falls on edge S+D+1+H after `button_n_i` returns to 1, whatever the length of the press.
- R8: A filtered cause that appears during the hold period keeps reset asserted and restarts the hold period from zero.
- R9: `rst_lo_o` is always the inverse of `rst_hi_o`.
- R10: If `rst` is released with no cause present, `rst_hi_o` falls on edge H+1 after the release.
- R11: If both causes are present, reset stays asserted until both have cleared. The hold period is then counted from the later release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_fail_i | input | 1 | Supply out of tolerance, active high, asynchronous |
| button_n_i | input | 1 | Pushbutton, active low, asynchronous, may bounce |
| rst_hi_o | output | 1 | Registered reset, active high |
| rst_lo_o | output | 1 | Registered reset, active low |

## Verification
The two filtered causes can be active in the same cycle. In that case the hold period must follow the later release and must ignore the earlier one. The bench provokes this by pressing the button and raising the supply flag together. It then drops the supply flag while the button is still held. The bench checks that reset stays high over that gap and that it falls exactly S+D+1+H edges after the button release. A second overlap, a cause that arrives during the hold period, is provoked by raising the supply flag partway through the hold period. The bench judges it by the fall time, measured from the new release.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;
  typedef enum logic [1:0] {
    ST_ASSERT = 2'd0,
    ST_HOLD   = 2'd1,
    ST_RUN    = 2'd2
  } sup_state_e;
endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstsup_glitch_filter.sv
module rstsup_glitch_filter #(
  parameter int FILT_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic fail_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] run_cnt;
  logic          fail_q;

  always_ff @(posedge clk) begin
    if (rst || !raw_i) begin
      run_cnt <= '0;
      fail_q  <= 1'b0;
    end else if (run_cnt == LAST) begin
      fail_q  <= 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assign fail_o = fail_q;

  AST_FILT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !raw_i |=> !fail_o);  // R6
  AST_FILT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_o) |-> $past(raw_i));  // R3
endmodule

// File: rtl/rstsup_debounce.sv
module rstsup_debounce #(
  parameter int DEB_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pressed_raw_i,
  output logic pressed_o
);
  localparam int CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [CW-1:0] diff_cnt;
  logic          level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      diff_cnt <= '0;
      level_q  <= 1'b0;
    end else if (pressed_raw_i == level_q) begin
      diff_cnt <= '0;
    end else if (diff_cnt == LAST) begin
      diff_cnt <= '0;
      level_q  <= ~level_q;
    end else begin
      diff_cnt <= diff_cnt + 1'b1;
    end
  end

  assign pressed_o = level_q;

  AST_DEB_STABLE: assert property (@(posedge clk) disable iff (rst)
    (pressed_raw_i == pressed_o) |=> $stable(pressed_o));  // R5
endmodule

// File: rtl/rstsup_hold_fsm.sv
module rstsup_hold_fsm
  import rstsup_pkg::*;
#(
  parameter int HOLD_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic cause_i,
  output logic rst_hi_o,
  output logic rst_lo_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  sup_state_e    state_q, state_d;
  logic [CW-1:0] hold_cnt_q, hold_cnt_d;
  logic          hi_q, lo_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ASSERT: if (!cause_i) state_d = ST_HOLD;
      ST_HOLD: begin
        if (cause_i)                 state_d = ST_ASSERT;
        else if (hold_cnt_q == LAST) state_d = ST_RUN;
      end
      ST_RUN:    if (cause_i) state_d = ST_ASSERT;
      default:   state_d = ST_ASSERT;
    endcase
  end

  always_comb begin
    if (state_d == ST_HOLD && state_q == ST_HOLD) hold_cnt_d = hold_cnt_q + 1'b1;
    else                                         hold_cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_ASSERT;
      hold_cnt_q <= '0;
      hi_q       <= 1'b1;
      lo_q       <= 1'b0;
    end else begin
      state_q    <= state_d;
      hold_cnt_q <= hold_cnt_d;
      hi_q       <= (state_d != ST_RUN);
      lo_q       <= (state_d == ST_RUN);
    end
  end

  assign rst_hi_o = hi_q;
  assign rst_lo_o = lo_q;

  AST_CAUSE_ASSERTS: assert property (@(posedge clk) disable iff (rst)
    cause_i |=> rst_hi_o);  // R2
  AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (rst)
    hold_cnt_q <= LAST);  // R6
  AST_RUN_AFTER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && $past(state_q) != ST_RUN) |-> $past(state_q) == ST_HOLD);  // R7
  AST_HOLD_RESTART: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD && cause_i) |=> (state_q == ST_ASSERT && hold_cnt_q == '0));  // R8
  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    rst_hi_o != rst_lo_o);  // R9
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int SYNC_STAGES  = 2,
  parameter int GLITCH_CYC   = 8,
  parameter int DEBOUNCE_CYC = 16,
  parameter int HOLD_CYC     = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_fail_i,
  input  logic button_n_i,
  output logic rst_hi_o,
  output logic rst_lo_o
);
  logic fail_sync, btn_n_sync;
  logic fail_filt, btn_pressed;
  logic any_cause;

  rstsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_fail (
    .clk(clk), .rst(rst), .d_i(supply_fail_i), .q_o(fail_sync));

  rstsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_btn (
    .clk(clk), .rst(rst), .d_i(button_n_i), .q_o(btn_n_sync));

  rstsup_glitch_filter #(.FILT_CYC(GLITCH_CYC)) u_filt (
    .clk(clk), .rst(rst), .raw_i(fail_sync), .fail_o(fail_filt));

  rstsup_debounce #(.DEB_CYC(DEBOUNCE_CYC)) u_deb (
    .clk(clk), .rst(rst), .pressed_raw_i(~btn_n_sync), .pressed_o(btn_pressed));

  assign any_cause = fail_filt | btn_pressed;

  rstsup_hold_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
    .clk(clk), .rst(rst), .cause_i(any_cause),
    .rst_hi_o(rst_hi_o), .rst_lo_o(rst_lo_o));

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (rst_hi_o && !rst_lo_o));  // R1
  AST_BOTH_CAUSES: assert property (@(posedge clk) disable iff (rst)
    (fail_filt && btn_pressed) |=> rst_hi_o);  // R11
endmodule

// File: tb/sim_rst_supervisor.sv
`timescale 1ns/1ps
module sim_rst_supervisor;
  localparam int S = 2, G = 8, D = 16, H = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_fail_i = 1'b0;
  logic button_n_i = 1'b1;
  logic rst_hi_o, rst_lo_o;

  int checks = 0, failures = 0, comp_err = 0;

  always #2 clk = ~clk;

  rst_supervisor #(.SYNC_STAGES(S), .GLITCH_CYC(G), .DEBOUNCE_CYC(D), .HOLD_CYC(H)) u0 (
    .clk(clk), .rst(rst), .supply_fail_i(supply_fail_i), .button_n_i(button_n_i),
    .rst_hi_o(rst_hi_o), .rst_lo_o(rst_lo_o));

  function automatic int exp_sup_on();  return S + G + 1;     endfunction
  function automatic int exp_btn_on();  return S + D + 1;     endfunction
  function automatic int exp_sup_off(); return S + 2 + H;     endfunction
  function automatic int exp_btn_off(); return S + D + 1 + H; endfunction
  function automatic int exp_pwr_off(); return H + 1;         endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample();
    if (rst_lo_o !== ~rst_hi_o) comp_err++;
  endtask

  // edges after the current negedge until rst_hi_o == want
  task automatic latency(input logic want, input int limit, output int lat);
    lat = -1;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk); #1;
      sample();
      if (lat < 0 && rst_hi_o == want) lat = k;
    end
  endtask

  // count cycles over n edges where rst_hi_o != want
  task automatic steady(input logic want, input int n, output int bad);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      sample();
      if (rst_hi_o != want) bad++;
    end
  endtask

  task automatic cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat, bad, len;
    void'($urandom(32'h5EED_1234));
    cycles(5);
    #1;
    chk("R1 hi during reset", rst_hi_o, 1);
    chk("R1 lo during reset", rst_lo_o, 0);

    @(negedge clk); rst = 1'b0;
    latency(1'b0, H + 20, lat);
    chk("R10 power-up hold", lat, exp_pwr_off());

    // directed: minimum filter lengths
    @(negedge clk); supply_fail_i = 1'b1;
    cycles(G - 1); supply_fail_i = 1'b0;
    steady(1'b0, G + S + 10, bad);
    chk("R3 pulse G-1 ignored", bad, 0);
    @(negedge clk); supply_fail_i = 1'b1;
    latency(1'b1, G + S + 5, lat);
    chk("R2 assert latency", lat, exp_sup_on());
    @(negedge clk); supply_fail_i = 1'b0;
    latency(1'b0, H + 20, lat);
    chk("R6 supply release hold", lat, exp_sup_off());

    @(negedge clk); button_n_i = 1'b0;
    cycles(D - 1); button_n_i = 1'b1;
    steady(1'b0, D + S + 10, bad);
    chk("R5 short press ignored", bad, 0);

    // release bounce during a long press
    @(negedge clk); button_n_i = 1'b0;
    latency(1'b1, D + S + 5, lat);
    chk("R4 press latency", lat, exp_btn_on());
    cycles(30); button_n_i = 1'b1;
    cycles(D - 1); button_n_i = 1'b0;
    steady(1'b1, H + 30, bad);
    chk("R5 release bounce ignored", bad, 0);
    @(negedge clk); button_n_i = 1'b1;
    latency(1'b0, H + D + 20, lat);
    chk("R7 button release hold", lat, exp_btn_off());

    // R8: cause during hold restarts it
    @(negedge clk); button_n_i = 1'b0;
    cycles(D + 10); button_n_i = 1'b1;
    cycles(H / 2);
    supply_fail_i = 1'b1;
    steady(1'b1, H, bad);
    chk("R8 stays high after restart", bad, 0);
    @(negedge clk); supply_fail_i = 1'b0;
    latency(1'b0, H + 20, lat);
    chk("R8 hold restarted", lat, exp_sup_off());

    // R11: both causes, supply clears first
    @(negedge clk); button_n_i = 1'b0; supply_fail_i = 1'b1;
    cycles(D + 20); supply_fail_i = 1'b0;
    steady(1'b1, 60, bad);
    chk("R11 held by button", bad, 0);
    @(negedge clk); button_n_i = 1'b1;
    latency(1'b0, H + D + 20, lat);
    chk("R11 hold from later release", lat, exp_btn_off());

    // constrained random
    for (int it = 0; it < 24; it++) begin
      int kind = int'($urandom_range(3, 0));
      @(negedge clk);
      case (kind)
        0: begin
          len = int'($urandom_range(G - 1, 1));
          supply_fail_i = 1'b1; cycles(len); supply_fail_i = 1'b0;
          steady(1'b0, G + S + 10, bad);
          chk("R3 random glitch ignored", bad, 0);
        end
        1: begin
          len = int'($urandom_range(D - 1, 1));
          button_n_i = 1'b0; cycles(len); button_n_i = 1'b1;
          steady(1'b0, D + S + 10, bad);
          chk("R5 random bounce ignored", bad, 0);
        end
        2: begin
          supply_fail_i = 1'b1;
          latency(1'b1, G + S + 5, lat);
          chk("R2 random assert", lat, exp_sup_on());
          cycles(int'($urandom_range(40, 0)));
          @(negedge clk); supply_fail_i = 1'b0;
          latency(1'b0, H + 20, lat);
          chk("R6 random release", lat, exp_sup_off());
        end
        default: begin
          button_n_i = 1'b0;
          latency(1'b1, D + S + 5, lat);
          chk("R4 random press", lat, exp_btn_on());
          cycles(int'($urandom_range(120, 0)));
          @(negedge clk); button_n_i = 1'b1;
          latency(1'b0, H + D + 20, lat);
          chk("R7 random release", lat, exp_btn_off());
        end
      endcase
    end

    chk("R9 complementary outputs", comp_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule